// File: doc/BRIEF.md
# Clear-on-Read Protection Status Register

This block gathers protection events from a power stage into one byte of status that software reads over the serial bus. Each event source has its own bit. A bit is set by a single-cycle event pulse and stays set until the next read of the register. Each source is classed either as a fault or as a warning. A fault also pulls the active-low open-drain alarm output low. A warning only records its bit.

A read strobe from the bus interface returns the byte as it stands in that cycle. The read then clears every bit. The alarm drive is released once the read has left no fault bit set. If an event arrives in the same cycle as a read, that event survives the clear, so no event is lost in the gap between sampling and clearing.

Top module: `fltstat_reg`

## Requirements
- R1: Output over-voltage maps to bit 7, thermal shutdown maps to bit 3, and input under-voltage maps to bit 1. Every other bit of `status_o` always reads 0.
- R2: An `ovp_evt_i` pulse sampled at a clock edge sets bit 7 and raises `flt_pull_low_o` as of that edge. Over-voltage is a fault.
- R3: A `tsd_evt_i` or `uvlo_evt_i` pulse sets bit 3 or bit 1 respectively at the sampling edge and leaves `flt_pull_low_o` low (released). These events are warnings.
- R4: A `rd_stb_i` sampled at an edge clears all status bits as of that edge, provided no event is sampled with it.
- R5: `flt_pull_low_o` stays high as long as bit 7 is set. It falls at the edge where a read leaves no fault bit set.
- R6: After reset, `status_o` is 0x00 and `flt_pull_low_o` is 0. The block has no write path.
- R7: An event sampled in the same cycle as `rd_stb_i` leaves its bit set after that read. If the event is a fault, the pin stays pulled low.
- R8: A set bit stays set while no read occurs, whatever its event input does.
- R9: The value on `status_o` during the cycle in which `rd_stb_i` is high is the value read. It holds every event recorded since the previous read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ovp_evt_i | input | 1 | Output over-voltage event pulse (fault) |
| tsd_evt_i | input | 1 | Thermal shutdown event pulse (warning) |
| uvlo_evt_i | input | 1 | Input under-voltage event pulse (warning) |
| rd_stb_i | input | 1 | Status read strobe from the bus interface |
| status_o | output | 8 | Status byte |
| flt_pull_low_o | output | 1 | 1 = drive the alarm pad low, 0 = release it |

## Verification
The bench uses the default parameters: an 8-bit register, bit positions 7/3/1, and only over-voltage classed as a fault. With these values every mix of fault and warning can be reached with a few pulses. The bench covers a warning held alone, a fault held alone, both classes together, and each event source colliding with a clearing read. It checks that the pin releases only on the read that empties the fault bits. It also checks that bits hold while their event inputs toggle with no read.

// File: rtl/fltstat_pkg.sv
package fltstat_pkg;

    // Event source index; its order also selects the class bit in FAULT_CLASS
    typedef enum int unsigned {
        EV_OVP  = 0,
        EV_TSD  = 1,
        EV_UVLO = 2
    } fs_evt_e;

    localparam int unsigned FS_NUM_EVT = 3;

endpackage

// File: rtl/fltstat_bit.sv
// Next-value logic of one sticky clear-on-read status bit
module fltstat_bit (
    input  logic cur_i,
    input  logic set_i,
    input  logic clr_i,
    output logic nxt_o
);
    // Set wins over clear so a colliding event is kept
    always_comb begin
        nxt_o = set_i | (cur_i & ~clr_i);
    end
endmodule

// File: rtl/fltstat_pin.sv
// Alarm drive decision from the next status value
module fltstat_pin #(
    parameter int unsigned STAT_W = 8
) (
    input  logic [STAT_W-1:0] stat_nxt_i,
    input  logic [STAT_W-1:0] fault_mask_i,
    output logic              pull_nxt_o
);
    always_comb begin
        pull_nxt_o = |(stat_nxt_i & fault_mask_i);
    end
endmodule

// File: rtl/fltstat_reg.sv
module fltstat_reg
    import fltstat_pkg::*;
#(
    parameter int unsigned STAT_W      = 8,
    parameter int unsigned OVP_BIT     = 7,
    parameter int unsigned TSD_BIT     = 3,
    parameter int unsigned UVLO_BIT    = 1,
    parameter logic [2:0]  FAULT_CLASS = 3'b001
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ovp_evt_i,
    input  logic              tsd_evt_i,
    input  logic              uvlo_evt_i,
    input  logic              rd_stb_i,
    output logic [STAT_W-1:0] status_o,
    output logic              flt_pull_low_o
);
    localparam int unsigned NUM_EVT = FS_NUM_EVT;
    localparam int unsigned POS [NUM_EVT] = '{OVP_BIT, TSD_BIT, UVLO_BIT};

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic              pull;
    } fs_state_t;

    fs_state_t state_d, state_q;

    logic [NUM_EVT-1:0] evt;
    logic [STAT_W-1:0]  evt_oh [NUM_EVT];
    logic [STAT_W-1:0]  flt_oh [NUM_EVT];
    logic [STAT_W-1:0]  set_vec;
    logic [STAT_W-1:0]  fault_mask;
    logic [STAT_W-1:0]  stat_nxt;
    logic               pull_nxt;

    always_comb begin
        evt          = '0;
        evt[EV_OVP]  = ovp_evt_i;
        evt[EV_TSD]  = tsd_evt_i;
        evt[EV_UVLO] = uvlo_evt_i;
    end

    // One-hot contribution of each source to the set vector and fault mask
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_src
        assign evt_oh[i] = evt[i] ? (STAT_W'(1) << POS[i]) : '0;
        assign flt_oh[i] = FAULT_CLASS[i] ? (STAT_W'(1) << POS[i]) : '0;
    end

    always_comb begin
        set_vec    = '0;
        fault_mask = '0;
        for (int i = 0; i < NUM_EVT; i++) begin
            set_vec    = set_vec | evt_oh[i];
            fault_mask = fault_mask | flt_oh[i];
        end
    end

    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        fltstat_bit u_bit (
            .cur_i (state_q.stat[b]),
            .set_i (set_vec[b]),
            .clr_i (rd_stb_i),
            .nxt_o (stat_nxt[b])
        );
    end

    fltstat_pin #(.STAT_W(STAT_W)) u_pin (
        .stat_nxt_i   (stat_nxt),
        .fault_mask_i (fault_mask),
        .pull_nxt_o   (pull_nxt)
    );

    always_comb begin
        state_d      = state_q;
        state_d.stat = stat_nxt;
        state_d.pull = pull_nxt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign status_o       = state_q.stat;
    assign flt_pull_low_o = state_q.pull;

endmodule

// File: rtl/fltstat_reg_chk.sv
module fltstat_reg_chk #(
    parameter int unsigned STAT_W      = 8,
    parameter int unsigned OVP_BIT     = 7,
    parameter int unsigned TSD_BIT     = 3,
    parameter int unsigned UVLO_BIT    = 1,
    parameter logic [2:0]  FAULT_CLASS = 3'b001
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              ovp_evt_i,
    input logic              tsd_evt_i,
    input logic              uvlo_evt_i,
    input logic              rd_stb_i,
    input logic [STAT_W-1:0] status_o,
    input logic              flt_pull_low_o
);
    localparam logic [STAT_W-1:0] USED =
        (STAT_W'(1) << OVP_BIT) | (STAT_W'(1) << TSD_BIT) | (STAT_W'(1) << UVLO_BIT);
    localparam logic [STAT_W-1:0] FMASK =
        (FAULT_CLASS[0] ? (STAT_W'(1) << OVP_BIT) : '0) |
        (FAULT_CLASS[1] ? (STAT_W'(1) << TSD_BIT) : '0) |
        (FAULT_CLASS[2] ? (STAT_W'(1) << UVLO_BIT) : '0);

    logic any_evt;
    assign any_evt = ovp_evt_i | tsd_evt_i | uvlo_evt_i;

    a_r1_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o & ~USED) == '0);

    a_r2_fault_pulls: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovp_evt_i |=> (flt_pull_low_o && status_o[OVP_BIT]));

    a_r3_warn_no_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((status_o & FMASK) == '0) |-> !flt_pull_low_o);

    a_r4_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_stb_i && !any_evt) |=> (status_o == '0));

    a_r5_pin_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((status_o & FMASK) != '0) |-> flt_pull_low_o);

    a_r7_collide_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_stb_i && tsd_evt_i) |=> status_o[TSD_BIT]);

    a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_stb_i |=> ((status_o & $past(status_o)) == $past(status_o)));

endmodule

bind fltstat_reg fltstat_reg_chk #(
    .STAT_W      (STAT_W),
    .OVP_BIT     (OVP_BIT),
    .TSD_BIT     (TSD_BIT),
    .UVLO_BIT    (UVLO_BIT),
    .FAULT_CLASS (FAULT_CLASS)
) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ovp_evt_i      (ovp_evt_i),
    .tsd_evt_i      (tsd_evt_i),
    .uvlo_evt_i     (uvlo_evt_i),
    .rd_stb_i       (rd_stb_i),
    .status_o       (status_o),
    .flt_pull_low_o (flt_pull_low_o)
);

// File: tb/fltstat_reg_tb.sv
module fltstat_reg_tb;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       ovp_evt_i = 1'b0;
    logic       tsd_evt_i = 1'b0;
    logic       uvlo_evt_i = 1'b0;
    logic       rd_stb_i = 1'b0;
    logic [7:0] status_o;
    logic       flt_pull_low_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // Bit values taken from R1
    localparam logic [7:0] B_OVP = 8'h80;
    localparam logic [7:0] B_TSD = 8'h08;
    localparam logic [7:0] B_UV  = 8'h02;

    always #4 clk_i = ~clk_i;

    fltstat_reg u_dut (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .ovp_evt_i      (ovp_evt_i),
        .tsd_evt_i      (tsd_evt_i),
        .uvlo_evt_i     (uvlo_evt_i),
        .rd_stb_i       (rd_stb_i),
        .status_o       (status_o),
        .flt_pull_low_o (flt_pull_low_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive for one clock edge; outputs are then sampled at the next falling edge
    task automatic step(input logic ovp, input logic tsd, input logic uv, input logic rd);
        ovp_evt_i  = ovp;
        tsd_evt_i  = tsd;
        uvlo_evt_i = uv;
        rd_stb_i   = rd;
        @(negedge clk_i);
        ovp_evt_i  = 1'b0;
        tsd_evt_i  = 1'b0;
        uvlo_evt_i = 1'b0;
        rd_stb_i   = 1'b0;
    endtask

    task automatic t_reset;
        chk("R6 status after reset", status_o, 8'h00);
        chk("R6 pin after reset", {7'd0, flt_pull_low_o}, 8'h00);
        step(0, 0, 0, 1);
        chk("R6 read-only, read leaves zero", status_o, 8'h00);
    endtask

    task automatic t_warning;
        step(0, 1, 0, 0);
        chk("R3 tsd bit 3", status_o, B_TSD);
        chk("R3 tsd no pin", {7'd0, flt_pull_low_o}, 8'h00);
        step(0, 0, 1, 0);
        chk("R3 uvlo bit 1 added", status_o, B_TSD | B_UV);
        chk("R3 warnings no pin", {7'd0, flt_pull_low_o}, 8'h00);
        chk("R9 value during read", status_o, B_TSD | B_UV);
        step(0, 0, 0, 1);
        chk("R4 read clears warnings", status_o, 8'h00);
    endtask

    task automatic t_fault;
        step(1, 0, 0, 0);
        chk("R2 ovp bit 7", status_o, B_OVP);
        chk("R2 pin low", {7'd0, flt_pull_low_o}, 8'h01);
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0);
        chk("R8 fault bit sticky", status_o, B_OVP);
        chk("R5 pin held while fault set", {7'd0, flt_pull_low_o}, 8'h01);
        step(0, 0, 0, 1);
        chk("R4 read clears fault", status_o, 8'h00);
        chk("R5 pin released after read", {7'd0, flt_pull_low_o}, 8'h00);
    endtask

    task automatic t_mixed;
        step(1, 1, 1, 0);
        chk("R1 all sources map to 7/3/1", status_o, B_OVP | B_TSD | B_UV);
        chk("R2 pin with mixed", {7'd0, flt_pull_low_o}, 8'h01);
        step(0, 1, 0, 1);
        chk("R7 tsd kept through read", status_o, B_TSD);
        chk("R5 pin released, only warning left", {7'd0, flt_pull_low_o}, 8'h00);
        step(0, 0, 0, 1);
        chk("R4 cleared", status_o, 8'h00);
    endtask

    task automatic t_collide_fault;
        step(1, 0, 0, 0);
        step(1, 0, 0, 1);
        chk("R7 ovp kept through read", status_o, B_OVP);
        chk("R7 pin stays low", {7'd0, flt_pull_low_o}, 8'h01);
        step(0, 0, 1, 1);
        chk("R7 uvlo kept, ovp cleared", status_o, B_UV);
        chk("R5 pin released", {7'd0, flt_pull_low_o}, 8'h00);
        step(0, 0, 0, 1);
    endtask

    task automatic t_sticky;
        step(0, 0, 1, 0);
        for (int i = 0; i < 4; i++) step(0, i[0], 0, 0);
        chk("R8 warnings sticky without read", status_o, B_TSD | B_UV);
        chk("R1 unused bits zero", status_o & ~(B_OVP | B_TSD | B_UV), 8'h00);
        step(0, 0, 0, 1);
        chk("R4 final clear", status_o, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_warning();
        t_fault();
        t_mixed();
        t_collide_fault();
        t_sticky();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule